// File: doc/BRIEF.md
# Store Completion Tracker

This block counts store arrivals for blocks of instructions that are in flight across four data tiles. It reports when every store of a block has arrived. A tile announces a local store with a frame number and a load/store identifier (the store's slot within its block, called the LSID). That announcement travels over a small status chain, one hop per cycle. As a result every tile holds its own copy of the per-frame arrival masks. The farthest tile gets the update three cycles after the tile where the store arrived.

Global control maps a frame by loading the number of stores the block header declares. Each tile compares the number of distinct identifiers in its mask with that count, and so each tile can detect completion by itself. Only the copy held by tile 0 produces the completion pulse sent to global control. A frame keeps its done state until it is cleared or mapped again. All arrival masks are exported so that deferred loads can be woken from them.

Top module: `stc_completion_tracker`

## Requirements
- R1: During and right after reset, every arrival mask is zero, and no completion or detection pulse is high.
- R2: A store arriving at tile t for a mapped frame sets bit LSID of that frame's mask in tile t's copy after the next clock edge. Tile t's copy is bits [(t*8+frame)*32 +: 32] of `wake_mask`.
- R3: The arrival reaches the copy of a tile at chain distance k = |t-d| exactly k cycles after it reaches tile t's own copy, so all four copies hold it within 3 cycles.
- R4: A repeated arrival of a (frame, LSID) pair that is already recorded does not add to the count.
- R5: When the number of distinct recorded LSIDs in tile 0's copy equals the frame's loaded count, `cmpl_pulse[frame]` goes high in the following cycle.
- R6: Completion is pulsed for one cycle only. Later arrivals for that frame give no further pulse until the frame is mapped again.
- R7: A frame mapped with a count of zero pulses completion in the cycle right after the map.
- R8: Mapping a frame loads its count and zeroes its masks in all tiles. Clearing a frame zeroes its masks and deactivates it. Nothing else removes mask bits.
- R9: Arrivals for a frame that is not mapped leave every mask unchanged and produce no pulse.
- R10: Arrivals at several tiles in the same cycle for the same frame are all recorded.
- R11: Each tile raises its own detection pulse `det_pulse[t*8+frame]` once its copy is complete. A tile far from the arrival therefore detects later than a tile near it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 4 | Store arrival strobe, one bit per tile |
| arr_frame | input | 12 | Frame number of each tile's arrival, 3 bits per tile |
| arr_lsid | input | 20 | LSID of each tile's arrival, 5 bits per tile |
| map_valid | input | 1 | Map a frame with a new store count |
| map_frame | input | 3 | Frame being mapped |
| map_count | input | 6 | Number of stores the block header declares (0 to 32) |
| clr_valid | input | 1 | Clear a frame on commit or flush |
| clr_frame | input | 3 | Frame being cleared |
| cmpl_pulse | output | 8 | Completion pulse per frame, taken from tile 0 |
| det_pulse | output | 32 | Completion detected per tile and frame, index tile*8+frame |
| wake_mask | output | 1024 | Arrival masks per tile and frame, 32 bits each, index (tile*8+frame)*32 |

## Verification
The bench uses the default values: four tiles, eight frames and thirty-two LSIDs. With these values the longest chain path, from tile 3 to tile 0, is three hops. The bench can therefore measure the full broadcast latency and the delayed completion pulse at tile 0 cycle by cycle. Eight frames let one frame sit done while other frames are mapped, cleared or left unmapped. With four tiles, four simultaneous arrivals to one frame arrive at tile 0 with delays of 0, 1, 2 and 3 cycles.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int STC_TILES  = 4;
  localparam int STC_FRAMES = 8;
  localparam int STC_LSIDS  = 32;
  localparam int STC_FW     = $clog2(STC_FRAMES);
  localparam int STC_LW     = $clog2(STC_LSIDS);
  localparam int STC_CW     = $clog2(STC_LSIDS + 1);
endpackage

// File: rtl/stc_status_net.sv
module stc_status_net #(
  parameter int NT = 4,
  parameter int EW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT*EW-1:0]    src_ev,
  output logic [NT*NT*EW-1:0] dst_ev
);
  // Linear chain: tile s reaches tile d after |s-d| registered hops.
  for (genvar s = 0; s < NT; s++) begin : g_src
    localparam int DEP = (s > NT - 1 - s) ? s : NT - 1 - s;
    logic [EW-1:0] tap [DEP+1];
    assign tap[0] = src_ev[s*EW +: EW];

    for (genvar k = 1; k <= DEP; k++) begin : g_hop
      logic          vld_q, vld_d;
      logic [EW-2:0] pay_q, pay_d;
      logic          pay_en;

      always_comb begin
        vld_d  = tap[k-1][EW-1];
        pay_d  = tap[k-1][EW-2:0];
        pay_en = tap[k-1][EW-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          pay_q <= '0;
        end else begin
          vld_q <= vld_d;
          if (pay_en) pay_q <= pay_d;
        end
      end

      assign tap[k] = {vld_q, pay_q};
    end

    for (genvar d = 0; d < NT; d++) begin : g_dst
      localparam int DIST = (s > d) ? s - d : d - s;
      assign dst_ev[(d*NT+s)*EW +: EW] = tap[DIST];
    end
  end
endmodule

// File: rtl/stc_frame_table.sv
module stc_frame_table #(
  parameter int NT = 4,
  parameter int NF = 8,
  parameter int NL = 32,
  parameter int FW = 3,
  parameter int LW = 5,
  parameter int CW = 6,
  localparam int EW = 1 + FW + LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_valid,
  input  logic [FW-1:0]    map_frame,
  input  logic [CW-1:0]    map_count,
  input  logic             clr_valid,
  input  logic [FW-1:0]    clr_frame,
  input  logic [NT*EW-1:0] ev_in,
  output logic [NF*NL-1:0] mask_o,
  output logic [NF-1:0]    det_o
);
  logic [NT-1:0] ev_vld;
  logic [FW-1:0] ev_frm  [NT];
  logic [LW-1:0] ev_lsid [NT];

  for (genvar p = 0; p < NT; p++) begin : g_unpack
    assign ev_vld[p]  = ev_in[p*EW + EW - 1];
    assign ev_frm[p]  = ev_in[p*EW + LW +: FW];
    assign ev_lsid[p] = ev_in[p*EW +: LW];
  end

  logic [NF-1:0] active_q, active_d;
  logic [NF-1:0] done_q, done_d;
  logic [NF-1:0] upd_en;
  logic [CW-1:0] cnt_q [NF];
  logic [CW-1:0] cnt_d [NF];
  logic [NL-1:0] mask_q [NF];
  logic [NL-1:0] mask_d [NF];
  logic [NL-1:0] set_bits [NF];

  // Arrival bits gathered from all chain ports
  always_comb begin
    for (int f = 0; f < NF; f++) begin
      set_bits[f] = '0;
      for (int p = 0; p < NT; p++) begin
        if (ev_vld[p] && ev_frm[p] == FW'(f)) set_bits[f][ev_lsid[p]] = 1'b1;
      end
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_frame
    logic map_hit, clr_hit;
    assign map_hit  = map_valid && map_frame == FW'(f);
    assign clr_hit  = clr_valid && clr_frame == FW'(f);
    assign det_o[f] = active_q[f] && !done_q[f] &&
                      ($countones(mask_q[f]) == int'(cnt_q[f]));
    assign mask_o[f*NL +: NL] = mask_q[f];

    always_comb begin
      active_d[f] = active_q[f];
      done_d[f]   = done_q[f];
      cnt_d[f]    = cnt_q[f];
      mask_d[f]   = mask_q[f];
      upd_en[f]   = 1'b0;
      if (map_hit) begin
        upd_en[f]   = 1'b1;
        active_d[f] = 1'b1;
        done_d[f]   = 1'b0;
        cnt_d[f]    = map_count;
        mask_d[f]   = '0;
      end else if (clr_hit) begin
        upd_en[f]   = 1'b1;
        active_d[f] = 1'b0;
        done_d[f]   = 1'b0;
        mask_d[f]   = '0;
      end else if (active_q[f]) begin
        upd_en[f]   = 1'b1;
        mask_d[f]   = mask_q[f] | set_bits[f];
        if (det_o[f]) done_d[f] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[f] <= 1'b0;
        done_q[f]   <= 1'b0;
        cnt_q[f]    <= '0;
        mask_q[f]   <= '0;
      end else if (upd_en[f]) begin
        active_q[f] <= active_d[f];
        done_q[f]   <= done_d[f];
        cnt_q[f]    <= cnt_d[f];
        mask_q[f]   <= mask_d[f];
      end
    end
  end
endmodule

// File: rtl/stc_completion_tracker.sv
module stc_completion_tracker
  import stc_pkg::*;
#(
  parameter int NT = STC_TILES,
  parameter int NF = STC_FRAMES,
  parameter int NL = STC_LSIDS,
  localparam int FW = $clog2(NF),
  localparam int LW = $clog2(NL),
  localparam int CW = $clog2(NL + 1),
  localparam int EW = 1 + FW + LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT-1:0]       arr_valid,
  input  logic [NT*FW-1:0]    arr_frame,
  input  logic [NT*LW-1:0]    arr_lsid,
  input  logic                map_valid,
  input  logic [FW-1:0]       map_frame,
  input  logic [CW-1:0]       map_count,
  input  logic                clr_valid,
  input  logic [FW-1:0]       clr_frame,
  output logic [NF-1:0]       cmpl_pulse,
  output logic [NT*NF-1:0]    det_pulse,
  output logic [NT*NF*NL-1:0] wake_mask
);
  logic [NT*EW-1:0]    src_ev;
  logic [NT*NT*EW-1:0] dst_ev;

  for (genvar t = 0; t < NT; t++) begin : g_src
    assign src_ev[t*EW +: EW] = {arr_valid[t], arr_frame[t*FW +: FW], arr_lsid[t*LW +: LW]};
  end

  stc_status_net #(.NT(NT), .EW(EW)) u_net (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_ev (src_ev),
    .dst_ev (dst_ev)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tile
    stc_frame_table #(
      .NT(NT), .NF(NF), .NL(NL), .FW(FW), .LW(LW), .CW(CW)
    ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .map_valid (map_valid),
      .map_frame (map_frame),
      .map_count (map_count),
      .clr_valid (clr_valid),
      .clr_frame (clr_frame),
      .ev_in     (dst_ev[t*NT*EW +: NT*EW]),
      .mask_o    (wake_mask[t*NF*NL +: NF*NL]),
      .det_o     (det_pulse[t*NF +: NF])
    );
  end

  // Only tile 0 reports to global control
  assign cmpl_pulse = det_pulse[NF-1:0];
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int NF = 8,
  parameter int NL = 32,
  parameter int FW = 3,
  parameter int LW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr0_valid,
  input logic [FW-1:0]    arr0_frame,
  input logic [LW-1:0]    arr0_lsid,
  input logic             map_valid,
  input logic [FW-1:0]    map_frame,
  input logic             clr_valid,
  input logic [FW-1:0]    clr_frame,
  input logic [NF-1:0]    cmpl_pulse,
  input logic [NF*NL-1:0] mask0
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1 : assert (cmpl_pulse == '0 && mask0 == '0)
        else $error("R1 outputs not quiet in reset");
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_f
    logic map_f, clr_f;
    logic [NL-1:0] m;
    assign map_f = map_valid && map_frame == FW'(f);
    assign clr_f = clr_valid && clr_frame == FW'(f);
    assign m     = mask0[f*NL +: NL];

    p_single_pulse_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_pulse[f] && !map_f |=> !cmpl_pulse[f])
      else $error("R6 repeated completion pulse");

    p_mask_keep_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !map_f && !clr_f |=> (($past(m) & ~m) == '0))
      else $error("R8 mask bit dropped without map or clear");

    p_local_seen_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      arr0_valid && arr0_frame == FW'(f) && !map_f && !clr_f
      |=> (m[$past(arr0_lsid)] || m == '0))
      else $error("R2 local arrival not recorded");
  end
endmodule

bind stc_completion_tracker stc_checker #(
  .NF(NF), .NL(NL), .FW(FW), .LW(LW)
) u_stc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr0_valid (arr_valid[0]),
  .arr0_frame (arr_frame[FW-1:0]),
  .arr0_lsid  (arr_lsid[LW-1:0]),
  .map_valid  (map_valid),
  .map_frame  (map_frame),
  .clr_valid  (clr_valid),
  .clr_frame  (clr_frame),
  .cmpl_pulse (cmpl_pulse),
  .mask0      (wake_mask[NF*NL-1:0])
);

// File: tb/test_stc_completion_tracker.sv
module test_stc_completion_tracker;
  import stc_pkg::*;
  localparam int NT = STC_TILES, NF = STC_FRAMES, NL = STC_LSIDS;
  localparam int FW = STC_FW, LW = STC_LW, CW = STC_CW;

  logic clk, rst_n;
  logic [NT-1:0] arr_valid;
  logic [NT*FW-1:0] arr_frame;
  logic [NT*LW-1:0] arr_lsid;
  logic map_valid, clr_valid;
  logic [FW-1:0] map_frame, clr_frame;
  logic [CW-1:0] map_count;
  logic [NF-1:0] cmpl_pulse;
  logic [NT*NF-1:0] det_pulse;
  logic [NT*NF*NL-1:0] wake_mask;

  int n_chk = 0, n_err = 0;

  stc_completion_tracker i_stc_completion_tracker (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [NL-1:0] mk(int t, int f);
    return wake_mask[(t*NF+f)*NL +: NL];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    arr_valid = '0; arr_frame = '0; arr_lsid = '0;
    map_valid = 0; map_frame = '0; map_count = '0;
    clr_valid = 0; clr_frame = '0;
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); idle(); end
  endtask

  task automatic arrive(int t, int f, int l);
    arr_valid[t] = 1'b1;
    arr_frame[t*FW +: FW] = FW'(f);
    arr_lsid[t*LW +: LW] = LW'(l);
  endtask

  task automatic map_f(int f, int c);
    map_valid = 1; map_frame = FW'(f); map_count = CW'(c);
  endtask

  task automatic t_reset();
    chk("R1 pulses", longint'(cmpl_pulse), 0);
    chk("R1 masks", longint'(wake_mask != '0), 0);
  endtask

  task automatic t_zero_count();
    map_f(2, 0); tick();
    chk("R7 zero-count pulse", longint'(cmpl_pulse), 64'h4);
    tick();
    chk("R6 pulse one cycle", longint'(cmpl_pulse), 0);
  endtask

  task automatic t_broadcast();
    map_f(1, 3); tick();
    arrive(0, 1, 5); tick();
    chk("R2 own tile", longint'(mk(0, 1)), 64'h20);
    chk("R3 tile1 not yet", longint'(mk(1, 1)), 0);
    tick();
    chk("R3 tile1 hop1", longint'(mk(1, 1)), 64'h20);
    chk("R3 tile2 not yet", longint'(mk(2, 1)), 0);
    tick();
    chk("R3 tile2 hop2", longint'(mk(2, 1)), 64'h20);
    chk("R3 tile3 not yet", longint'(mk(3, 1)), 0);
    tick();
    chk("R3 tile3 hop3", longint'(mk(3, 1)), 64'h20);
  endtask

  task automatic t_dup_and_complete();
    arrive(2, 1, 5); tick(4);
    chk("R4 duplicate count", longint'($countones(mk(0, 1))), 1);
    arrive(1, 1, 9); tick(4);
    chk("R4 no early completion", longint'(cmpl_pulse), 0);
    arrive(3, 1, 20); tick();
    chk("R11 tile3 detects", longint'(det_pulse[3*NF+1]), 1);
    chk("R5 tile0 not yet", longint'(cmpl_pulse), 0);
    tick();
    chk("R11 tile3 detect once", longint'(det_pulse[3*NF+1]), 0);
    tick(2);
    chk("R5 completion at tile0", longint'(cmpl_pulse), 64'h2);
    tick();
    chk("R6 completion single", longint'(cmpl_pulse), 0);
  endtask

  task automatic t_no_repulse();
    int seen = 0;
    arrive(0, 1, 30);
    for (int i = 0; i < 6; i++) begin tick(); if (cmpl_pulse[1]) seen++; end
    chk("R6 no second pulse", seen, 0);
  endtask

  task automatic t_clear_remap();
    clr_valid = 1; clr_frame = 3'd1; tick();
    for (int t = 0; t < NT; t++) chk("R8 clear zeroes", longint'(mk(t, 1)), 0);
    map_f(1, 1); tick();
    arrive(0, 1, 0); tick();
    chk("R8 remap completes", longint'(cmpl_pulse), 64'h2);
  endtask

  task automatic t_unmapped();
    arrive(1, 6, 3); tick(5);
    for (int t = 0; t < NT; t++) chk("R9 unmapped ignored", longint'(mk(t, 6)), 0);
    chk("R9 no pulse", longint'(cmpl_pulse), 0);
  endtask

  task automatic t_simultaneous();
    map_f(4, 4); tick();
    for (int t = 0; t < NT; t++) arrive(t, 4, t + 1);
    tick();
    chk("R10 tile0 first edge", longint'(mk(0, 4)), 64'h2);
    tick(2);
    chk("R10 no pulse before hop3", longint'(cmpl_pulse), 0);
    tick();
    for (int t = 0; t < NT; t++) chk("R10 all recorded", longint'(mk(t, 4)), 64'h1E);
    chk("R5 multi-source completion", longint'(cmpl_pulse), 64'h10);
    map_f(4, 2); tick();
    chk("R8 map zeroes mask", longint'(mk(3, 4)), 0);
    chk("R8 remapped not done", longint'(cmpl_pulse), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_zero_count();
    t_broadcast();
    t_dup_and_complete();
    t_no_repulse();
    t_clear_remap();
    t_unmapped();
    t_simultaneous();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule